// File: doc/BRIEF.md
# Two-Cluster Snooping Read Coherency Controller

This controller connects two cache clusters to one memory read port and keeps their copies of a line coherent on reads. A cluster asks for a line on its request channel. Before the memory port is touched, the controller sends a snoop for that address to the other cluster (the peer) and waits for its response.

On a snoop miss the controller reads the line from memory and tells the requester to install it as UniqueClean. On a snoop hit it takes the line from the peer's snoop data channel and does not read memory. The requester then installs it as SharedClean. If the peer's copy was dirty, the requester installs it as SharedDirty and the peer is expected to drop to SharedClean, so only one holder is responsible for the dirty data.

The controller serves one transaction at a time. When both clusters request in the same cycle, a round-robin choice decides which one goes first. Every channel uses a valid/ready pair, and a transfer takes place only in a cycle where both are high.

Top module: `coh_link_ctrl`

## Requirements
- R1: A synchronous active-high reset, including one during a transaction, returns the block to idle. After it, with no request pending, every valid and ready output is low. The first arbitration after reset favours cluster 0.
- R2: At most one bit of `req_ready` is high at a time. While a transaction is in progress, `req_ready` stays 0 even if the other cluster is requesting.
- R3: When both clusters request in the same idle cycle, the cluster that was not granted last wins. Two back-to-back contended arbitrations therefore grant cluster 0 and then cluster 1.
- R4: An accepted request first raises `snp_valid` only toward the peer, carrying the requested address. `mem_ar_valid` cannot rise before that snoop has been accepted. The snoop and its address are held until `snp_ready` is seen.
- R5: A snoop response with hit=0 makes the block raise `mem_ar_valid` with the requested address and hold both until `mem_ar_ready`.
- R6: On a miss, the response carries the memory read data with `rsp_state` = 1 (UniqueClean).
- R7: On a hit with dirty=0, the response carries the peer's lane of `snp_data`, with `rsp_state` = 3 (SharedClean), and no memory read is issued.
- R8: On a hit with dirty=1, the response carries the peer's data with `rsp_state` = 4 (SharedDirty). State codes are Invalid 0, UniqueClean 1, UniqueDirty 2, SharedClean 3, SharedDirty 4.
- R9: The response is valid only on the requester's bit of `rsp_valid`, never carries state 0 while valid, and holds its data until `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Read request valid, bit i from cluster i |
| req_ready | output | 2 | Read request accepted, bit i to cluster i |
| req_addr | input | 2*AW | Request addresses, cluster i in lane i |
| rsp_valid | output | 2 | Read response valid toward cluster i |
| rsp_ready | input | 2 | Read response accepted by cluster i |
| rsp_data | output | DW | Returned line |
| rsp_state | output | 3 | Coherency state the requester must install |
| snp_valid | output | 2 | Snoop address valid toward cluster i |
| snp_ready | input | 2 | Snoop address accepted by cluster i |
| snp_addr | output | AW | Snoop address |
| sresp_valid | input | 2 | Snoop response valid from cluster i |
| sresp_ready | output | 2 | Snoop response accepted from cluster i |
| sresp_hit | input | 2 | Cluster i holds the line |
| sresp_dirty | input | 2 | Cluster i's copy is dirty |
| sdata_valid | input | 2 | Snoop data valid from cluster i |
| sdata_ready | output | 2 | Snoop data accepted from cluster i |
| sdata | input | 2*DW | Snoop data, cluster i in lane i |
| mem_ar_valid | output | 1 | Memory read address valid |
| mem_ar_ready | input | 1 | Memory read address accepted |
| mem_ar_addr | output | AW | Memory read address |
| mem_r_valid | input | 1 | Memory read data valid |
| mem_r_ready | output | 1 | Memory read data accepted |
| mem_r_data | input | DW | Memory read data |

## Verification
The embedded assertions check the rules that hold on every cycle: a single grant, no grant while busy, held snoop, memory and response handshakes under back-pressure, a valid response never carrying Invalid, and no memory read after a hit. Only the directed scenarios can show the data path and the protocol decisions. These are the snoop going to the peer before memory with the right address, the right data source, the right state code for miss, clean hit and dirty hit, the round-robin rotation, and recovery from a reset in the middle of a transaction.

// File: rtl/coh_link_ctrl.sv
module coh_link_ctrl #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      req_valid,
  output logic [1:0]      req_ready,
  input  logic [2*AW-1:0] req_addr,
  output logic [1:0]      rsp_valid,
  input  logic [1:0]      rsp_ready,
  output logic [DW-1:0]   rsp_data,
  output logic [2:0]      rsp_state,
  output logic [1:0]      snp_valid,
  input  logic [1:0]      snp_ready,
  output logic [AW-1:0]   snp_addr,
  input  logic [1:0]      sresp_valid,
  output logic [1:0]      sresp_ready,
  input  logic [1:0]      sresp_hit,
  input  logic [1:0]      sresp_dirty,
  input  logic [1:0]      sdata_valid,
  output logic [1:0]      sdata_ready,
  input  logic [2*DW-1:0] sdata,
  output logic            mem_ar_valid,
  input  logic            mem_ar_ready,
  output logic [AW-1:0]   mem_ar_addr,
  input  logic            mem_r_valid,
  output logic            mem_r_ready,
  input  logic [DW-1:0]   mem_r_data
);

  localparam logic [2:0] ST_INV = 3'd0;
  localparam logic [2:0] ST_UC  = 3'd1;
  localparam logic [2:0] ST_UD  = 3'd2;
  localparam logic [2:0] ST_SC  = 3'd3;
  localparam logic [2:0] ST_SD  = 3'd4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SNP, PH_SRSP, PH_SDAT, PH_MAR, PH_MRD, PH_RSP
  } phase_t;

  phase_t          phase;
  logic            own;
  logic            last;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;
  logic [2:0]      grant_q;
  logic [1:0]      pick;
  logic            peer;
  logic [1:0]      own_oh;
  logic [1:0]      peer_oh;

  always_comb begin
    if (req_valid == 2'b11) pick = last ? 2'b01 : 2'b10;
    else                    pick = req_valid;
  end

  assign peer    = ~own;
  assign own_oh  = own ? 2'b10 : 2'b01;
  assign peer_oh = ~own_oh;

  assign req_ready    = (phase == PH_IDLE) ? pick : 2'b00;
  assign snp_valid    = (phase == PH_SNP)  ? peer_oh : 2'b00;
  assign snp_addr     = addr_q;
  assign sresp_ready  = (phase == PH_SRSP) ? peer_oh : 2'b00;
  assign sdata_ready  = (phase == PH_SDAT) ? peer_oh : 2'b00;
  assign mem_ar_valid = (phase == PH_MAR);
  assign mem_ar_addr  = addr_q;
  assign mem_r_ready  = (phase == PH_MRD);
  assign rsp_valid    = (phase == PH_RSP)  ? own_oh : 2'b00;
  assign rsp_data     = data_q;
  assign rsp_state    = (phase == PH_RSP)  ? grant_q : ST_INV;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      own     <= 1'b0;
      last    <= 1'b1;
      addr_q  <= '0;
      data_q  <= '0;
      grant_q <= ST_INV;
    end else begin
      case (phase)
        PH_IDLE: if (|pick) begin
          own    <= pick[1];
          last   <= pick[1];
          addr_q <= pick[1] ? req_addr[2*AW-1:AW] : req_addr[AW-1:0];
          phase  <= PH_SNP;
        end
        PH_SNP: if (snp_ready[peer]) phase <= PH_SRSP;
        PH_SRSP: if (sresp_valid[peer]) begin
          if (sresp_hit[peer]) begin
            grant_q <= sresp_dirty[peer] ? ST_SD : ST_SC;
            phase   <= PH_SDAT;
          end else begin
            grant_q <= ST_UC;
            phase   <= PH_MAR;
          end
        end
        PH_SDAT: if (sdata_valid[peer]) begin
          data_q <= peer ? sdata[2*DW-1:DW] : sdata[DW-1:0];
          phase  <= PH_RSP;
        end
        PH_MAR: if (mem_ar_ready) phase <= PH_MRD;
        PH_MRD: if (mem_r_valid) begin
          data_q <= mem_r_data;
          phase  <= PH_RSP;
        end
        PH_RSP: if (rsp_ready[own]) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));

  // R2
  busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_valid != 2'b00 || mem_ar_valid || rsp_valid != 2'b00) |-> req_ready == 2'b00);

  // R4
  snp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_valid != 2'b00 && (snp_valid & snp_ready) == 2'b00)
      |=> snp_valid == $past(snp_valid) && $stable(snp_addr));

  // R5
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_ar_valid && !mem_ar_ready) |=> mem_ar_valid && $stable(mem_ar_addr));

  // R7
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    ((sresp_valid & sresp_ready & sresp_hit) != 2'b00) |=> !mem_ar_valid);

  // R9
  rsp_state_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid != 2'b00) |-> (rsp_state != ST_INV && rsp_state != ST_UD));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid != 2'b00 && (rsp_valid & rsp_ready) == 2'b00)
      |=> rsp_valid == $past(rsp_valid) && $stable(rsp_data) && $stable(rsp_state));

endmodule

// File: tb/test_coh_link_ctrl.sv
module test_coh_link_ctrl;
  localparam int AW = 32;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] req_valid, req_ready, rsp_valid, rsp_ready;
  logic [2*AW-1:0] req_addr;
  logic [DW-1:0] rsp_data;
  logic [2:0] rsp_state;
  logic [1:0] snp_valid, snp_ready, sresp_valid, sresp_ready, sresp_hit, sresp_dirty;
  logic [1:0] sdata_valid, sdata_ready;
  logic [AW-1:0] snp_addr, mem_ar_addr;
  logic [2*DW-1:0] sdata;
  logic mem_ar_valid, mem_ar_ready, mem_r_valid, mem_r_ready;
  logic [DW-1:0] mem_r_data;

  int n_run = 0;
  int n_fail = 0;

  // captured by serve
  logic [1:0]    c_tgt, c_rv;
  logic [AW-1:0] c_saddr, c_maddr;
  logic          c_mem;
  logic [DW-1:0] c_rdat;
  logic [2:0]    c_state;

  always #4 clk = ~clk;

  coh_link_ctrl #(.AW(AW), .DW(DW)) i_coh_link_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_state(rsp_state),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_addr(snp_addr),
    .sresp_valid(sresp_valid), .sresp_ready(sresp_ready), .sresp_hit(sresp_hit),
    .sresp_dirty(sresp_dirty), .sdata_valid(sdata_valid), .sdata_ready(sdata_ready),
    .sdata(sdata), .mem_ar_valid(mem_ar_valid), .mem_ar_ready(mem_ar_ready),
    .mem_ar_addr(mem_ar_addr), .mem_r_valid(mem_r_valid), .mem_r_ready(mem_r_ready),
    .mem_r_data(mem_r_data)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic quiet_responders();
    snp_ready = '0; sresp_valid = '0; sresp_hit = '0; sresp_dirty = '0;
    sdata_valid = '0; sdata = '0; mem_ar_ready = 1'b0; mem_r_valid = 1'b0;
    mem_r_data = '0; rsp_ready = '0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // raise a request and wait until accepted; drop it afterwards
  task automatic issue(input int rq, input logic [AW-1:0] a);
    @(negedge clk);
    req_valid[rq] = 1'b1;
    req_addr[rq*AW +: AW] = a;
    #1;
    while (!req_ready[rq]) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid[rq] = 1'b0;
  endtask

  // act as peer cache, memory and requester response sink until the response is taken
  task automatic serve(input bit hit, input bit dirty, input logic [DW-1:0] pd,
                       input logic [DW-1:0] md, input int stall);
    bit saw_snp = 0, snp_done = 0, rp = 0, dp = 0, mp = 0, done = 0, saw_rsp = 0;
    int ctr = 0;
    int pr = 0;
    c_tgt = '0; c_rv = '0; c_saddr = '0; c_maddr = '0; c_mem = 0; c_rdat = '0; c_state = '0;
    for (int cyc = 0; cyc < 300 && !done; cyc++) begin
      @(negedge clk);
      snp_ready    = (snp_valid != 2'b00 && ctr >= stall) ? snp_valid : 2'b00;
      sresp_valid  = rp ? (2'b01 << pr) : 2'b00;
      sresp_hit    = hit ? (2'b01 << pr) : 2'b00;
      sresp_dirty  = dirty ? (2'b01 << pr) : 2'b00;
      sdata_valid  = dp ? (2'b01 << pr) : 2'b00;
      sdata        = '1;
      sdata[pr*DW +: DW] = pd;
      mem_ar_ready = mem_ar_valid && ctr >= stall;
      mem_r_valid  = mp;
      mem_r_data   = md;
      rsp_ready    = (rsp_valid != 2'b00 && ctr >= stall) ? rsp_valid : 2'b00;
      #3;
      if (req_ready != 2'b00) check(0, "R2", "req_ready while busy", req_ready, 0);
      if (snp_valid != 2'b00) begin
        if (!saw_snp) begin
          saw_snp = 1; c_tgt = snp_valid; c_saddr = snp_addr;
          pr = snp_valid[1] ? 1 : 0;
        end else if (snp_addr != c_saddr || snp_valid != c_tgt)
          check(0, "R4", "snoop changed while stalled", snp_addr, c_saddr);
        if ((snp_valid & snp_ready) != 2'b00) begin snp_done = 1; rp = 1; ctr = 0; end
        else ctr++;
      end
      if ((sresp_valid & sresp_ready) != 2'b00) begin rp = 0; dp = hit; end
      if ((sdata_valid & sdata_ready) != 2'b00) dp = 0;
      if (mem_ar_valid) begin
        if (!snp_done) check(0, "R4", "memory read before snoop accepted", 1, 0);
        if (c_mem && mem_ar_addr != c_maddr)
          check(0, "R5", "memory address changed while stalled", mem_ar_addr, c_maddr);
        c_mem = 1; c_maddr = mem_ar_addr;
        if (mem_ar_ready) begin mp = 1; ctr = 0; end
        else ctr++;
      end
      if (mem_r_valid && mem_r_ready) mp = 0;
      if (rsp_valid != 2'b00) begin
        if (saw_rsp && (rsp_data != c_rdat || rsp_valid != c_rv))
          check(0, "R9", "response changed while stalled", rsp_data, c_rdat);
        saw_rsp = 1; c_rv = rsp_valid; c_rdat = rsp_data; c_state = rsp_state;
        if ((rsp_valid & rsp_ready) != 2'b00) done = 1;
        else ctr++;
      end
    end
    if (!done) check(0, "R9", "response never completed", 0, 1);
    @(negedge clk);
    quiet_responders();
  endtask

  task automatic t_reset();
    #1;
    check(req_ready == 0 && rsp_valid == 0 && snp_valid == 0 && !mem_ar_valid
          && sresp_ready == 0 && sdata_ready == 0 && !mem_r_ready,
          "R1", "outputs idle after reset",
          {req_ready, rsp_valid, snp_valid, mem_ar_valid, mem_r_ready}, 0);
  endtask

  task automatic t_miss(input int rq, input logic [AW-1:0] a, input int stall);
    logic [DW-1:0] md = {32'hC0DE0000, a};
    issue(rq, a);
    serve(0, 0, ~md, md, stall);
    check(c_tgt == (rq ? 2'b01 : 2'b10), "R4", "snoop target is peer", c_tgt, rq ? 1 : 2);
    check(c_saddr == a, "R4", "snoop address", c_saddr, a);
    check(c_mem && c_maddr == a, "R5", "memory read address", c_maddr, a);
    check(c_rdat == md, "R6", "miss data from memory", c_rdat, md);
    check(c_state == 3'd1, "R6", "miss state UniqueClean", c_state, 1);
    check(c_rv == (rq ? 2'b10 : 2'b01), "R9", "response to requester", c_rv, rq ? 2 : 1);
  endtask

  task automatic t_hit(input int rq, input logic [AW-1:0] a, input bit dirty, input int stall);
    logic [DW-1:0] pd = {32'hBEEF0000, a};
    issue(rq, a);
    serve(1, dirty, pd, ~pd, stall);
    check(c_tgt == (rq ? 2'b01 : 2'b10), "R4", "hit snoop target", c_tgt, rq ? 1 : 2);
    check(!c_mem, "R7", "no memory read on hit", c_mem, 0);
    check(c_rdat == pd, dirty ? "R8" : "R7", "hit data from peer lane", c_rdat, pd);
    if (dirty) check(c_state == 3'd4, "R8", "dirty hit SharedDirty", c_state, 4);
    else       check(c_state == 3'd3, "R7", "clean hit SharedClean", c_state, 3);
    check(c_rv == (rq ? 2'b10 : 2'b01), "R9", "hit response to requester", c_rv, rq ? 2 : 1);
  endtask

  task automatic t_arb();
    @(negedge clk);
    req_addr = {32'h0000_2200, 32'h0000_1100};
    req_valid = 2'b11;
    #1;
    check(req_ready == 2'b01, "R3", "first contended grant", req_ready, 1);
    @(negedge clk);
    req_valid = 2'b10;
    serve(0, 0, 64'h1, 64'h1234, 1);
    check(c_saddr == 32'h1100 && c_tgt == 2'b10, "R3", "cluster 0 served first", c_saddr, 32'h1100);
    req_valid = 2'b11;
    #1;
    check(req_ready == 2'b10, "R3", "second contended grant", req_ready, 2);
    @(negedge clk);
    req_valid = 2'b00;
    serve(1, 0, 64'h5678, 64'h0, 0);
    check(c_saddr == 32'h2200 && c_tgt == 2'b01, "R3", "cluster 1 served second", c_saddr, 32'h2200);
  endtask

  task automatic t_reset_mid();
    issue(1, 32'h0000_7700);
    @(negedge clk);
    #1;
    check(snp_valid == 2'b01, "R4", "snoop pending before reset", snp_valid, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    @(negedge clk);
    req_addr = {32'h0000_9900, 32'h0000_8800};
    req_valid = 2'b11;
    #1;
    check(req_ready == 2'b01, "R1", "first grant after reset favours cluster 0", req_ready, 1);
    @(negedge clk);
    req_valid = 2'b00;
    serve(0, 0, 64'h0, 64'hAAAA, 0);
    check(c_rdat == 64'hAAAA && c_state == 3'd1, "R1", "clean transaction after reset", c_rdat, 64'hAAAA);
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst = 1'b1;
    req_valid = '0;
    req_addr = '0;
    quiet_responders();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_miss(0, 32'h0000_0040, 0);
    t_hit(1, 32'h0000_0080, 0, 2);
    t_hit(0, 32'h0000_00C0, 1, 3);
    t_miss(1, 32'h0000_0100, 3);
    t_hit(1, 32'h0000_0140, 1, 0);
    t_arb();
    t_reset_mid();
    finish_run();
  end
endmodule